// File: doc/BRIEF.md
# Dual-Slot DMA Descriptor Buffer

This block keeps up to two channel descriptors waiting for a downstream address counter. Each descriptor holds a source address, a destination address, a remaining count and a control word. The counter works through the descriptor in one slot. Meanwhile an upstream engine can already load the next channel's descriptor into the other slot. When the counter signals completion, the buffer switches to the other slot, so the next channel starts without any setup gap.

The counter writes each updated descriptor back into the slot it is being shown. A slot counts as occupied while its count is nonzero. The upstream engine offers a descriptor with a valid signal, and the buffer takes it in any cycle where it raises its ready output. A 2-bit occupancy code, built from the two counts, chooses which slot receives the new descriptor. Everything is clocked, with a synchronous active-high reset.

Top module: `dma_slot_buffer`

## Requirements
- R1: After reset both slots have count zero and the selector is 0. With no write-back pending, in_ready is 1, out_valid is 0, out_sel is 0 and out_cnt is 0.
- R2: The occupancy code has slot 1's count nonzero in bit 0 and slot 2's count nonzero in bit 1. With code 00 or 10, an accepted descriptor (in_valid and in_ready both high at a clock edge) is stored into slot 1.
- R3: With occupancy code 01, an accepted descriptor is stored into slot 2.
- R4: With occupancy code 11, in_ready is 0 and the offered descriptor is not stored.
- R5: The selector toggles at the clock edge after each cycle in which done is 1 and was 0 in the previous cycle. If done stays high, there is no further toggle.
- R6: With selector 0 the outputs show slot 1. With selector 1 they show slot 2. out_sel shows the selector.
- R7: When wb_valid is 1 at a clock edge, the write-back descriptor replaces the slot shown before that edge. This holds even if the selector toggles at the same edge.
- R8: If the slot chosen for the upstream descriptor is the slot being shown and wb_valid is 1, in_ready is 0 for that cycle. An upstream write and a write-back into different slots both take effect in the same cycle.
- R9: out_valid is 1 exactly when the shown slot's count is nonzero. A slot the selector has moved to while it is empty reads invalid until a nonzero count is loaded into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream descriptor offered |
| in_ready | output | 1 | Upstream descriptor can be taken this cycle |
| in_src | input | 32 | Upstream source address |
| in_dst | input | 32 | Upstream destination address |
| in_cnt | input | 32 | Upstream remaining count |
| in_ctl | input | 32 | Upstream control word |
| wb_valid | input | 1 | Counter write-back present |
| wb_src | input | 32 | Write-back source address |
| wb_dst | input | 32 | Write-back destination address |
| wb_cnt | input | 32 | Write-back remaining count |
| wb_ctl | input | 32 | Write-back control word |
| done | input | 1 | Channel completion from the counter |
| out_valid | output | 1 | Shown slot holds a nonzero count |
| out_sel | output | 1 | Selector: 0 shows slot 1, 1 shows slot 2 |
| out_src | output | 32 | Shown source address |
| out_dst | output | 32 | Shown destination address |
| out_cnt | output | 32 | Shown remaining count |
| out_ctl | output | 32 | Shown control word |

## Verification
The bench fills both slots and then offers a third descriptor. A buffer that ignores code 11 would overwrite a live channel. It drives a write-back in the same cycle as a completion, to show that the write-back lands in the old slot and not the new one. It holds done high for several cycles, which catches a selector that follows the level instead of the edge. It also offers an upstream descriptor aimed at the shown slot during a write-back, where a missing stall would let the upstream data win or merge with the counter's data. Last, it switches to an empty slot and then loads that slot, checking that out_valid drops and later recovers.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  localparam int DSB_DW    = 32;
  localparam int DSB_SLOTS = 2;
  localparam int DSB_IW    = $clog2(DSB_SLOTS);

  typedef struct packed {
    logic [DSB_DW-1:0] src;
    logic [DSB_DW-1:0] dst;
    logic [DSB_DW-1:0] cnt;
    logic [DSB_DW-1:0] ctl;
  } desc_t;
endpackage

// File: rtl/dsb_slot_pick.sv
module dsb_slot_pick
  import dsb_pkg::*;
(
  input  logic [DSB_SLOTS-1:0] occ,
  output logic [DSB_IW-1:0]    tgt,
  output logic                 full
);
  always_comb begin
    full = 1'b0;
    tgt  = '0;
    unique case (occ)
      2'b00, 2'b10: tgt = 1'b0;
      2'b01:        tgt = 1'b1;
      default:      full = 1'b1;
    endcase
  end
endmodule

// File: rtl/dsb_sel_toggle.sv
module dsb_sel_toggle (
  input  logic clk,
  input  logic rst,
  input  logic done,
  output logic sel
);
  logic done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      sel    <= 1'b0;
    end else begin
      done_q <= done;
      if (done && !done_q) sel <= ~sel;
    end
  end
endmodule

// File: rtl/dsb_slot_store.sv
module dsb_slot_store
  import dsb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 up_we,
  input  logic [DSB_IW-1:0]    up_idx,
  input  desc_t                up_desc,
  input  logic                 wb_we,
  input  logic [DSB_IW-1:0]    wb_idx,
  input  desc_t                wb_desc,
  output desc_t                slot_q [DSB_SLOTS],
  output logic [DSB_SLOTS-1:0] occ
);
  for (genvar i = 0; i < DSB_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q[i] <= '0;
      end else if (wb_we && wb_idx == DSB_IW'(i)) begin
        slot_q[i] <= wb_desc;
      end else if (up_we && up_idx == DSB_IW'(i)) begin
        slot_q[i] <= up_desc;
      end
    end
    assign occ[i] = |slot_q[i].cnt;
  end
endmodule

// File: rtl/dma_slot_buffer.sv
module dma_slot_buffer
  import dsb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DSB_DW-1:0] in_src,
  input  logic [DSB_DW-1:0] in_dst,
  input  logic [DSB_DW-1:0] in_cnt,
  input  logic [DSB_DW-1:0] in_ctl,
  input  logic              wb_valid,
  input  logic [DSB_DW-1:0] wb_src,
  input  logic [DSB_DW-1:0] wb_dst,
  input  logic [DSB_DW-1:0] wb_cnt,
  input  logic [DSB_DW-1:0] wb_ctl,
  input  logic              done,
  output logic              out_valid,
  output logic              out_sel,
  output logic [DSB_DW-1:0] out_src,
  output logic [DSB_DW-1:0] out_dst,
  output logic [DSB_DW-1:0] out_cnt,
  output logic [DSB_DW-1:0] out_ctl
);
  logic [DSB_SLOTS-1:0] occ;
  logic [DSB_IW-1:0]    tgt;
  logic                 full;
  logic                 sel;
  logic                 accept;
  desc_t                up_desc, wb_desc, shown;
  desc_t                slot_q [DSB_SLOTS];

  assign up_desc = '{src: in_src, dst: in_dst, cnt: in_cnt, ctl: in_ctl};
  assign wb_desc = '{src: wb_src, dst: wb_dst, cnt: wb_cnt, ctl: wb_ctl};

  dsb_slot_pick u_pick (.occ(occ), .tgt(tgt), .full(full));

  dsb_sel_toggle u_sel (.clk(clk), .rst(rst), .done(done), .sel(sel));

  assign in_ready = !full && !(wb_valid && tgt == sel);
  assign accept   = in_valid && in_ready;

  dsb_slot_store u_store (
    .clk(clk), .rst(rst),
    .up_we(accept), .up_idx(tgt), .up_desc(up_desc),
    .wb_we(wb_valid), .wb_idx(sel), .wb_desc(wb_desc),
    .slot_q(slot_q), .occ(occ)
  );

  assign shown     = slot_q[sel];
  assign out_valid = |shown.cnt;
  assign out_sel   = sel;
  assign out_src   = shown.src;
  assign out_dst   = shown.dst;
  assign out_cnt   = shown.cnt;
  assign out_ctl   = shown.ctl;
endmodule

// File: rtl/dsb_checker.sv
module dsb_checker
  import dsb_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              wb_valid,
  input logic [DSB_DW-1:0] wb_cnt,
  input logic              done,
  input logic              out_sel,
  input logic              out_valid,
  input logic [DSB_DW-1:0] out_cnt,
  input logic [1:0]        occ,
  input logic              tgt
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !wb_valid) |-> (in_ready && !out_valid && !out_sel));

  // R4
  full_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == 2'b11) |-> !in_ready);

  // R5
  sel_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(done)) |=> (out_sel != $past(out_sel)));

  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$rose(done)) |=> $stable(out_sel));

  // R7
  wb_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && wb_valid && !$rose(done)) |=> (out_cnt == $past(wb_cnt)));

  // R8
  no_same_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && in_valid && in_ready) |-> (tgt != out_sel));
endmodule

bind dma_slot_buffer dsb_checker u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .wb_valid(wb_valid), .wb_cnt(wb_cnt), .done(done), .out_sel(out_sel),
  .out_valid(out_valid), .out_cnt(out_cnt), .occ(occ), .tgt(tgt)
);

// File: tb/dma_slot_buffer_bench.sv
module dma_slot_buffer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, wb_valid = 1'b0, done = 1'b0;
  logic [31:0] in_src = '0, in_dst = '0, in_cnt = '0, in_ctl = '0;
  logic [31:0] wb_src = '0, wb_dst = '0, wb_cnt = '0, wb_ctl = '0;
  logic        in_ready, out_valid, out_sel;
  logic [31:0] out_src, out_dst, out_cnt, out_ctl;
  int          checks = 0, errors = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  dma_slot_buffer u_dma_slot_buffer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_dst(in_dst), .in_cnt(in_cnt), .in_ctl(in_ctl),
    .wb_valid(wb_valid), .wb_src(wb_src), .wb_dst(wb_dst), .wb_cnt(wb_cnt),
    .wb_ctl(wb_ctl), .done(done), .out_valid(out_valid), .out_sel(out_sel),
    .out_src(out_src), .out_dst(out_dst), .out_cnt(out_cnt), .out_ctl(out_ctl)
  );

  typedef struct packed {
    logic        iv;
    logic [7:0]  icnt;
    logic [15:0] isrc;
    logic        wv;
    logic [7:0]  wcnt;
    logic [15:0] wsrc;
    logic        dn;
    logic        rdy;
    logic        ov;
    logic [7:0]  ocnt;
    logic [15:0] osrc;
    logic        osel;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    // R2: empty buffer, descriptor goes to slot 1
    '{1'b1, 8'd3, 16'h1000, 1'b0, 8'd0, 16'h0000, 1'b0, 1'b1, 1'b1, 8'd3, 16'h1000, 1'b0},
    // R3: code 01, goes to slot 2, output stays slot 1 (R6)
    '{1'b1, 8'd2, 16'h2000, 1'b0, 8'd0, 16'h0000, 1'b0, 1'b1, 1'b1, 8'd3, 16'h1000, 1'b0},
    // R4: both full, refused; R7 write-back to slot 1
    '{1'b1, 8'd5, 16'h3000, 1'b1, 8'd2, 16'h1004, 1'b0, 1'b0, 1'b1, 8'd2, 16'h1004, 1'b0},
    // R7
    '{1'b0, 8'd0, 16'h0000, 1'b1, 8'd1, 16'h1008, 1'b0, 1'b0, 1'b1, 8'd1, 16'h1008, 1'b0},
    // R5 R7: last write-back with completion, switch to slot 2
    '{1'b0, 8'd0, 16'h0000, 1'b1, 8'd0, 16'h100C, 1'b1, 1'b0, 1'b1, 8'd2, 16'h2000, 1'b1},
    // R2 R8: code 10 load slot 1 while write-back to slot 2
    '{1'b1, 8'd4, 16'h4000, 1'b1, 8'd1, 16'h2004, 1'b0, 1'b1, 1'b1, 8'd1, 16'h2004, 1'b1},
    // R5: completion of slot 2, back to slot 1; R4 full
    '{1'b0, 8'd0, 16'h0000, 1'b1, 8'd0, 16'h2008, 1'b1, 1'b0, 1'b1, 8'd4, 16'h4000, 1'b0},
    // R5: done held high, no toggle
    '{1'b0, 8'd0, 16'h0000, 1'b0, 8'd0, 16'h0000, 1'b1, 1'b1, 1'b1, 8'd4, 16'h4000, 1'b0},
    '{1'b0, 8'd0, 16'h0000, 1'b0, 8'd0, 16'h0000, 1'b0, 1'b1, 1'b1, 8'd4, 16'h4000, 1'b0},
    // R9: toggle to empty slot 2, invalid
    '{1'b0, 8'd0, 16'h0000, 1'b0, 8'd0, 16'h0000, 1'b1, 1'b1, 1'b0, 8'd0, 16'h2008, 1'b1},
    // R8: target is shown slot during write-back, stalled
    '{1'b1, 8'd6, 16'h5000, 1'b1, 8'd9, 16'h7777, 1'b0, 1'b0, 1'b1, 8'd9, 16'h7777, 1'b1},
    // R8 R9
    '{1'b1, 8'd6, 16'h5000, 1'b1, 8'd0, 16'h7778, 1'b0, 1'b0, 1'b0, 8'd0, 16'h7778, 1'b1},
    // R3 R9: load the shown empty slot, valid again
    '{1'b1, 8'd6, 16'h5000, 1'b0, 8'd0, 16'h0000, 1'b0, 1'b1, 1'b1, 8'd6, 16'h5000, 1'b1},
    // R4: full again, refused, output unchanged
    '{1'b1, 8'd7, 16'h6000, 1'b0, 8'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 8'd6, 16'h5000, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #5;
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 out_sel", {31'd0, out_sel}, 32'd0);
    check("R1 out_cnt", out_cnt, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_valid = VEC[i].iv;
      in_cnt   = {24'd0, VEC[i].icnt};
      in_src   = {16'd0, VEC[i].isrc};
      in_dst   = {16'd0, VEC[i].isrc} + 32'h100;
      in_ctl   = 32'h1;
      wb_valid = VEC[i].wv;
      wb_cnt   = {24'd0, VEC[i].wcnt};
      wb_src   = {16'd0, VEC[i].wsrc};
      wb_dst   = {16'd0, VEC[i].wsrc} + 32'h100;
      wb_ctl   = 32'h1;
      done     = VEC[i].dn;
      #2;
      check($sformatf("R4/R8 in_ready row %0d", i), {31'd0, in_ready}, {31'd0, VEC[i].rdy});
      @(posedge clk);
      #5;
      check($sformatf("R9 out_valid row %0d", i), {31'd0, out_valid}, {31'd0, VEC[i].ov});
      check($sformatf("R6 out_cnt row %0d", i), out_cnt, {24'd0, VEC[i].ocnt});
      check($sformatf("R6 out_src row %0d", i), out_src, {16'd0, VEC[i].osrc});
      check($sformatf("R5 out_sel row %0d", i), {31'd0, out_sel}, {31'd0, VEC[i].osel});
    end

    // R6: destination field follows the shown slot (slot 2 loaded with 0x5000)
    check("R6 out_dst", out_dst, 32'h5100);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    in_valid = 1'b0; wb_valid = 1'b0; done = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #5;
    check("R1 mid in_ready", {31'd0, in_ready}, 32'd1);
    check("R1 mid out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 mid out_sel", {31'd0, out_sel}, 32'd0);
    check("R1 mid out_cnt", out_cnt, 32'd0);

    // R2: after reset the new descriptor lands in slot 1
    @(negedge clk);
    in_valid = 1'b1; in_cnt = 32'd8; in_src = 32'hABCD; in_dst = 32'h1234;
    @(posedge clk);
    #5;
    in_valid = 1'b0;
    check("R2 post-reset cnt", out_cnt, 32'd8);
    check("R2 post-reset src", out_src, 32'hABCD);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule